// File: doc/BRIEF.md
# Cache-Line Error Tracking and Delete Controller

This controller sits behind the SEC-DED check on a cache's read path, where each data word is protected by a 72-bit codeword carrying 64 data bits. For every checked read it receives a flag for a correctable error (CE), a flag for an uncorrectable error (UE), the failing bit position within the codeword, the line index and whether the line holds modified data. Every error produces a purge command for the line and a log record of where it failed.

Correctable errors are screened against a per-area trap that remembers the bit of the last correctable failure in that area. A repeat in the identical bit marks the line as a hard fault and deletes it. A correctable error in a different bit only reloads the trap. Uncorrectable errors tell the requester the data is invalid. A clean line is just invalidated, because storage still holds a good copy. A modified line is written back flagged as bad, the address is reported and the line is deleted.

Deleted lines are kept in a mask that an allocator consults, so a deleted line is never handed out again until the mask is explicitly cleared. Both streams follow valid/ready rules. The event input is always ready, so the controller takes one event per cycle and never applies back-pressure. The log output holds a record stable until `log_ready` accepts it. A record that arrives while the log is full is dropped and raises a sticky overflow flag.

Top module: `cled_ctrl`

## Requirements
- R1: While `rst_n` is low and after it is released, no action outputs are asserted, `del_mask` is all zero, `log_valid` and `log_ovf` are 0, every area trap is empty, and the allocation pointer is 0.
- R2: An accepted event with `ev_ce` or `ev_ue` set raises `purge_cmd` for exactly the next cycle, with `evt_line` equal to `ev_line`. An event with neither flag set raises no action output.
- R3: A CE whose area trap is empty, or holds a different bit, loads the trap with `ev_bit` and does not delete the line. The area is the top log2(AREAS) bits of the line index.
- R4: A CE whose area trap holds the same `ev_bit` sets `del_mask[ev_line]` from the next cycle on. Traps of different areas are independent.
- R5: A UE raises `data_bad` for the next cycle. If `ev_dirty` is 0, it raises neither `bad_wback` nor `addr_notify`, and it does not delete the line.
- R6: A UE with `ev_dirty` = 1 also raises `bad_wback` and `addr_notify` for the next cycle, and it sets `del_mask[ev_line]`. An event with both flags set is handled as a UE.
- R7: Any combination of lines can be deleted. `mask_clear` zeroes the mask on the next cycle. A delete caused in the same cycle as `mask_clear` survives the clear.
- R8: `alloc_req` gives `alloc_vld` on the next cycle. `alloc_line` is the first line not in `del_mask`, searching upward with wrap-around from a pointer. The pointer then moves to the line after the granted one. If every line is deleted, `alloc_none` is 1 and the pointer is unchanged.
- R9: Every error event pushes the record {`log_is_ue`, `log_line`, `log_bit`} into the log in arrival order. A record shown on the outputs stays stable while `log_valid` is 1 and `log_ready` is 0.
- R10: An error event that arrives while the log holds DEPTH records is dropped and sets `log_ovf`, which stays at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | Check result valid |
| ev_ready | output | 1 | Always 1; one event accepted per cycle |
| ev_ce | input | 1 | Correctable error flag |
| ev_ue | input | 1 | Uncorrectable error flag |
| ev_dirty | input | 1 | Line holds modified data |
| ev_line | input | LINE_W | Line index |
| ev_bit | input | BIT_W | Failing bit position in codeword |
| purge_cmd | output | 1 | Purge the line in evt_line |
| data_bad | output | 1 | Tell requester data is invalid |
| bad_wback | output | 1 | Write line back flagged permanently bad |
| addr_notify | output | 1 | Report failed address |
| evt_line | output | LINE_W | Line the action outputs refer to |
| mask_clear | input | 1 | Clear all deleted-line marks |
| del_mask | output | LINES | One bit per deleted line |
| alloc_req | input | 1 | Request a line to allocate |
| alloc_vld | output | 1 | Allocation answer valid |
| alloc_none | output | 1 | No usable line left |
| alloc_line | output | LINE_W | Granted line |
| log_valid | output | 1 | Log record available |
| log_ready | input | 1 | Consumer takes the log record |
| log_is_ue | output | 1 | Record is an uncorrectable error |
| log_line | output | LINE_W | Logged line index |
| log_bit | output | BIT_W | Logged bit position |
| log_ovf | output | 1 | Sticky: a record was dropped |

## Verification
The decision logic is driven by a table of error events. The table contains a clean read, first and differing CEs in one area, a same-bit CE repeat in one area against a fresh CE in a neighbouring area, clean and modified UEs, and a read with both flags set. Together these separate a trap hit from a trap reload, separate per-area trap state, and separate the invalidate-only path from the delete path. Directed runs then fill the mask completely, to check the allocator's skip, wrap and exhaustion cases and the order of clear against delete. A further run stalls the log consumer, to check record order and the boundary at which a record is dropped.

// File: rtl/cled_pkg.sv
package cled_pkg;

  typedef enum logic [1:0] {
    EV_NONE     = 2'd0,
    EV_CE       = 2'd1,
    EV_UE_CLEAN = 2'd2,
    EV_UE_DIRTY = 2'd3
  } ev_class_e;

  // An uncorrectable flag dominates a correctable one on the same read.
  function automatic ev_class_e classify(input logic vld, input logic ce,
                                         input logic ue, input logic dirty);
    if (!vld)     return EV_NONE;
    if (ue)       return dirty ? EV_UE_DIRTY : EV_UE_CLEAN;
    if (ce)       return EV_CE;
    return EV_NONE;
  endfunction

endpackage

// File: rtl/cled_trap.sv
module cled_trap #(
  parameter int AREAS  = 4,
  parameter int BIT_W  = 7,
  localparam int AREA_W = $clog2(AREAS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd,
  input  logic [AREA_W-1:0] area,
  input  logic [BIT_W-1:0]  bitpos,
  output logic              hit
);

  logic             tv [AREAS];
  logic [BIT_W-1:0] tb [AREAS];

  generate
    for (genvar a = 0; a < AREAS; a++) begin : g_area
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          tv[a] <= 1'b0;
          tb[a] <= '0;
        end else if (upd && (area == AREA_W'(a))) begin
          tv[a] <= 1'b1;
          tb[a] <= bitpos;
        end
      end
    end
  endgenerate

  always_comb hit = tv[area] && (tb[area] == bitpos);

endmodule

// File: rtl/cled_delmask.sv
module cled_delmask #(
  parameter int LINES  = 16,
  localparam int LINE_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic [LINE_W-1:0] set_line,
  input  logic              clr,
  output logic [LINES-1:0]  mask
);

  logic [LINES-1:0] mask_nxt;

  always_comb begin
    mask_nxt = clr ? '0 : mask;
    if (set_en) mask_nxt[set_line] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask <= '0;
    else        mask <= mask_nxt;
  end

  // R7: without a clear, no deleted line ever returns
  assert_mask_grows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((mask & $past(mask)) == $past(mask)));

  // R7: a delete requested together with a clear is kept
  assert_clear_keeps_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && set_en) |=> $countones(mask) == 1);

endmodule

// File: rtl/cled_alloc.sv
module cled_alloc #(
  parameter int LINES  = 16,
  localparam int LINE_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [LINES-1:0]  mask,
  output logic              vld,
  output logic              none,
  output logic [LINE_W-1:0] line
);

  logic [LINE_W-1:0] ptr;
  logic [LINE_W-1:0] pick;
  logic              found;
  logic [LINES-1:0]  mask_d;

  always_comb begin
    found = 1'b0;
    pick  = ptr;
    for (int i = 0; i < LINES; i++) begin
      int idx;
      idx = (int'(ptr) + i) % LINES;
      if (!found && !mask[idx]) begin
        found = 1'b1;
        pick  = LINE_W'(idx);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr  <= '0;
      vld  <= 1'b0;
      none <= 1'b0;
      line <= '0;
    end else begin
      vld <= req;
      if (req) begin
        none <= !found;
        if (found) begin
          line <= pick;
          ptr  <= (pick == LINE_W'(LINES - 1)) ? '0 : pick + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_d <= '0;
    else        mask_d <= mask;
  end

  // R8: a granted line was not deleted when the grant was made
  assert_alloc_skips_deleted_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && !none) |-> !mask_d[line]);

  // R8: exhaustion is only reported when every line was deleted
  assert_none_only_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && none) |-> (&mask_d));

endmodule

// File: rtl/cled_logfifo.sv
module cled_logfifo #(
  parameter int DEPTH = 4,
  parameter int W     = 12,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  output logic         valid,
  input  logic         ready,
  output logic [W-1:0] dout,
  output logic         ovf
);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wp, rp;
  logic [CNT_W-1:0] cnt;
  logic             full, wr, rd;

  always_comb begin
    full  = (cnt == CNT_W'(DEPTH));
    valid = (cnt != '0);
    wr    = push && !full;
    rd    = valid && ready;
    dout  = mem[rp];
  end

  always_ff @(posedge clk) begin
    if (wr) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
      ovf <= 1'b0;
    end else begin
      if (wr) wp <= (wp == PTR_W'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (rd) rp <= (rp == PTR_W'(DEPTH - 1)) ? '0 : rp + 1'b1;
      cnt <= cnt + CNT_W'(wr) - CNT_W'(rd);
      if (push && full) ovf <= 1'b1;
    end
  end

  // R9: an offered record is held until taken
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid && $stable(dout)));

  // R10: the drop flag never falls without reset
  assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);

  // R10: occupancy never passes the depth
  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(DEPTH));

endmodule

// File: rtl/cled_ctrl.sv
module cled_ctrl #(
  parameter int LINES  = 16,
  parameter int AREAS  = 4,
  parameter int CW_BITS = 72,
  parameter int DEPTH  = 4,
  localparam int LINE_W = $clog2(LINES),
  localparam int AREA_W = $clog2(AREAS),
  localparam int BIT_W  = $clog2(CW_BITS),
  localparam int REC_W  = 1 + LINE_W + BIT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  output logic              ev_ready,
  input  logic              ev_ce,
  input  logic              ev_ue,
  input  logic              ev_dirty,
  input  logic [LINE_W-1:0] ev_line,
  input  logic [BIT_W-1:0]  ev_bit,
  output logic              purge_cmd,
  output logic              data_bad,
  output logic              bad_wback,
  output logic              addr_notify,
  output logic [LINE_W-1:0] evt_line,
  input  logic              mask_clear,
  output logic [LINES-1:0]  del_mask,
  input  logic              alloc_req,
  output logic              alloc_vld,
  output logic              alloc_none,
  output logic [LINE_W-1:0] alloc_line,
  output logic              log_valid,
  input  logic              log_ready,
  output logic              log_is_ue,
  output logic [LINE_W-1:0] log_line,
  output logic [BIT_W-1:0]  log_bit,
  output logic              log_ovf
);
  import cled_pkg::*;

  ev_class_e         cls;
  logic [AREA_W-1:0] area;
  logic              trap_hit, is_err, is_ue, del_set;
  logic [REC_W-1:0]  rec_in, rec_out;

  assign ev_ready = 1'b1;

  always_comb begin
    cls     = classify(ev_valid, ev_ce, ev_ue, ev_dirty);
    area    = ev_line[LINE_W-1 -: AREA_W];
    is_err  = (cls != EV_NONE);
    is_ue   = (cls == EV_UE_CLEAN) || (cls == EV_UE_DIRTY);
    del_set = ((cls == EV_CE) && trap_hit) || (cls == EV_UE_DIRTY);
    rec_in  = {is_ue, ev_line, ev_bit};
  end

  cled_trap #(.AREAS(AREAS), .BIT_W(BIT_W)) u_trap (
    .clk(clk), .rst_n(rst_n), .upd(cls == EV_CE), .area(area),
    .bitpos(ev_bit), .hit(trap_hit)
  );

  cled_delmask #(.LINES(LINES)) u_mask (
    .clk(clk), .rst_n(rst_n), .set_en(del_set), .set_line(ev_line),
    .clr(mask_clear), .mask(del_mask)
  );

  cled_alloc #(.LINES(LINES)) u_alloc (
    .clk(clk), .rst_n(rst_n), .req(alloc_req), .mask(del_mask),
    .vld(alloc_vld), .none(alloc_none), .line(alloc_line)
  );

  cled_logfifo #(.DEPTH(DEPTH), .W(REC_W)) u_log (
    .clk(clk), .rst_n(rst_n), .push(is_err), .din(rec_in),
    .valid(log_valid), .ready(log_ready), .dout(rec_out), .ovf(log_ovf)
  );

  assign {log_is_ue, log_line, log_bit} = rec_out;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      purge_cmd   <= 1'b0;
      data_bad    <= 1'b0;
      bad_wback   <= 1'b0;
      addr_notify <= 1'b0;
      evt_line    <= '0;
    end else begin
      purge_cmd   <= is_err;
      data_bad    <= is_ue;
      bad_wback   <= (cls == EV_UE_DIRTY);
      addr_notify <= (cls == EV_UE_DIRTY);
      if (is_err) evt_line <= ev_line;
    end
  end

  // R2: a read without error flags produces no purge
  assert_clean_no_purge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && !ev_ce && !ev_ue) |=> !purge_cmd);

  // R5: clean uncorrectable error invalidates without write-back
  assert_ue_clean_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_ue && !ev_dirty) |=> (data_bad && !bad_wback && !addr_notify));

  // R6: modified uncorrectable error deletes the line
  assert_ue_dirty_del_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_ue && ev_dirty) |=> (bad_wback && addr_notify && del_mask[evt_line]));

  // R6: a bad write-back always comes with invalid data and a purge
  assert_wback_implies_inv_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bad_wback |-> (data_bad && purge_cmd));

endmodule

// File: tb/cled_ctrl_tb.sv
`timescale 1ns/1ps
module cled_ctrl_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic ev_valid = 0, ev_ce = 0, ev_ue = 0, ev_dirty = 0;
  logic [3:0] ev_line = 0;
  logic [6:0] ev_bit = 0;
  logic mask_clear = 0, alloc_req = 0, log_ready = 0;
  logic ev_ready, purge_cmd, data_bad, bad_wback, addr_notify;
  logic [3:0] evt_line, alloc_line, log_line;
  logic [15:0] del_mask;
  logic alloc_vld, alloc_none, log_valid, log_is_ue, log_ovf;
  logic [6:0] log_bit;

  cled_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_ce(ev_ce), .ev_ue(ev_ue), .ev_dirty(ev_dirty), .ev_line(ev_line),
    .ev_bit(ev_bit), .purge_cmd(purge_cmd), .data_bad(data_bad),
    .bad_wback(bad_wback), .addr_notify(addr_notify), .evt_line(evt_line),
    .mask_clear(mask_clear), .del_mask(del_mask), .alloc_req(alloc_req),
    .alloc_vld(alloc_vld), .alloc_none(alloc_none), .alloc_line(alloc_line),
    .log_valid(log_valid), .log_ready(log_ready), .log_is_ue(log_is_ue),
    .log_line(log_line), .log_bit(log_bit), .log_ovf(log_ovf)
  );

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive one event for one edge; outputs are then valid at this negedge
  task automatic ev(input logic ce, input logic ue, input logic dirty,
                    input logic [3:0] line, input logic [6:0] b);
    ev_valid = 1; ev_ce = ce; ev_ue = ue; ev_dirty = dirty;
    ev_line = line; ev_bit = b;
    @(negedge clk);
    ev_valid = 0; ev_ce = 0; ev_ue = 0; ev_dirty = 0;
  endtask

  task automatic alloc(input logic [3:0] exp_line, input logic exp_none);
    alloc_req = 1;
    @(negedge clk);
    alloc_req = 0;
    check("R8 alloc_vld", alloc_vld, 1);
    check("R8 alloc_none", alloc_none, exp_none);
    if (!exp_none) check("R8 alloc_line", alloc_line, exp_line);
  endtask

  // {ce, ue, dirty, line[3:0], bit[6:0], purge, inv, wback, deleted}
  localparam logic [17:0] TBL [10] = '{
    {1'b0,1'b0,1'b0,4'd1, 7'd0,  1'b0,1'b0,1'b0,1'b0}, // clean read
    {1'b1,1'b0,1'b0,4'd1, 7'd5,  1'b1,1'b0,1'b0,1'b0}, // R3 first CE area0
    {1'b1,1'b0,1'b0,4'd2, 7'd6,  1'b1,1'b0,1'b0,1'b0}, // R3 differing bit
    {1'b1,1'b0,1'b0,4'd3, 7'd6,  1'b1,1'b0,1'b0,1'b1}, // R4 same bit -> delete
    {1'b1,1'b0,1'b0,4'd4, 7'd6,  1'b1,1'b0,1'b0,1'b0}, // R4 other area independent
    {1'b0,1'b1,1'b0,4'd5, 7'd0,  1'b1,1'b1,1'b0,1'b0}, // R5 clean UE
    {1'b0,1'b1,1'b1,4'd9, 7'd0,  1'b1,1'b1,1'b1,1'b1}, // R6 dirty UE
    {1'b1,1'b1,1'b0,4'd10,7'd3,  1'b1,1'b1,1'b0,1'b0}, // R6 both flags -> UE
    {1'b1,1'b0,1'b0,4'd12,7'd71, 1'b1,1'b0,1'b0,1'b0}, // R3 area3 top bit
    {1'b1,1'b0,1'b0,4'd13,7'd71, 1'b1,1'b0,1'b0,1'b1}  // R4 repeat top bit
  };

  initial begin
    repeat (3) @(negedge clk);
    check("R1 purge after reset", purge_cmd, 0);
    check("R1 del_mask", del_mask, 0);
    check("R1 log_valid", log_valid, 0);
    check("R1 log_ovf", log_ovf, 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 alloc_vld", alloc_vld, 0);
    check("R1 ev_ready", ev_ready, 1);
    log_ready = 1;

    for (int i = 0; i < 10; i++) begin
      logic [17:0] v;
      v = TBL[i];
      ev(v[17], v[16], v[15], v[14:11], v[10:4]);
      check("R2 purge", purge_cmd, v[3]);
      if (v[3]) check("R2 evt_line", evt_line, v[14:11]);
      check("R5 data_bad", data_bad, v[2]);
      check("R6 bad_wback", bad_wback, v[1]);
      check("R6 addr_notify", addr_notify, v[1]);
      check("R3/R4 deleted", del_mask[v[14:11]], v[0]);
    end
    check("R7 combined mask", del_mask, 16'h2208);

    // allocation from pointer 0 skipping line 3
    alloc(4'd0, 0);
    alloc(4'd1, 0);
    alloc(4'd2, 0);
    alloc(4'd4, 0);

    // delete every line through modified UEs
    for (int l = 0; l < 16; l++) ev(1'b0, 1'b1, 1'b1, 4'(l), 7'd1);
    check("R7 all deleted", del_mask, 16'hFFFF);
    alloc(4'd0, 1);

    // clear and delete in the same cycle
    mask_clear = 1;
    ev(1'b0, 1'b1, 1'b1, 4'd7, 7'd2);
    mask_clear = 0;
    check("R7 clear keeps same-cycle delete", del_mask, 16'h0080);
    alloc(4'd5, 0);
    alloc(4'd6, 0);
    alloc(4'd8, 0);
    mask_clear = 1;
    @(negedge clk);
    mask_clear = 0;
    check("R7 clear empties mask", del_mask, 0);

    // log ordering and overflow with stalled consumer
    repeat (2) @(negedge clk);
    log_ready = 0;
    check("R9 log drained", log_valid, 0);
    for (int k = 0; k < 4; k++) ev(1'b1, 1'b0, 1'b0, 4'(k), 7'(10 + k));
    check("R10 no ovf at depth", log_ovf, 0);
    check("R9 log_valid", log_valid, 1);
    ev(1'b1, 1'b0, 1'b0, 4'd4, 7'd14);
    check("R10 ovf set", log_ovf, 1);
    for (int k = 0; k < 4; k++) begin
      check("R9 log_line", log_line, 4'(k));
      check("R9 log_bit", log_bit, 7'(10 + k));
      check("R9 log_is_ue", log_is_ue, 0);
      log_ready = 1;
      @(negedge clk);
      log_ready = 0;
    end
    check("R10 dropped record absent", log_valid, 0);
    check("R10 ovf sticky", log_ovf, 1);

    // UE record kind and reset state again
    ev(1'b0, 1'b1, 1'b0, 4'd11, 7'd33);
    check("R9 ue kind", log_is_ue, 1);
    check("R9 ue line", log_line, 4'd11);
    rst_n = 0;
    @(negedge clk);
    check("R1 ovf cleared", log_ovf, 0);
    check("R1 log empty", log_valid, 0);
    rst_n = 1;
    @(negedge clk);
    alloc(4'd0, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
      $finish;
    end
  end

endmodule